// File: doc/BRIEF.md
# Edge-Triggered GPIO Bank

A bank of up to 32 general-purpose pins behind a small word-addressed register port. Each pin has its own control word that picks whether the pin drives or listens and which edge, if any, raises its interrupt. Software drives output pins through write-one set and write-one clear ports, so no read-modify-write is needed. It reads the driven values and the sampled pad levels back from two status words.

Edge events latch into a sticky status word that software clears by writing ones. A mask word holds back selected pins from the single bank interrupt line. Bits are masked through one address and unmasked through another, so each write touches only the pins it names. Pad inputs are assumed to be already synchronised to `clk`. Write protection and debouncing are handled elsewhere.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every pin is an input (`pad_oe` = 0), `pad_out` = 0, all pins are masked (mask word reads all ones), the status word reads 0 and `irq` is low.
- R2: The control word of pin p is at byte address 0x100 + 4p. Bit 0 = 1 makes the pin an input and 0 makes it an output, and `pad_oe[p]` is the inverse of bit 0. Bits 4:3 hold the trigger code. Reads return only bits 0, 3 and 4; all other bits read 0.
- R3: Writing ones to 0x040 sets, and writing ones to 0x060 clears, the corresponding output bits; zero bits leave them unchanged. The output word reads at 0x000 and drives `pad_out`. Reads of 0x040 and 0x060 return 0.
- R4: A read of 0x020 returns the current `pad_in` levels.
- R5: Trigger code 1 latches a status bit on a rising pad edge, code 2 on a falling edge and code 3 on either edge. The bit is visible after the first clock edge at which the pad differs from its level at the previous clock edge.
- R6: Trigger code 0 never sets the status bit.
- R7: The status word reads at 0x080. Writing a 1 to a bit there clears it, and 0 bits have no effect.
- R8: If an edge event and a clear of the same status bit fall in the same cycle, the bit stays set.
- R9: Writing ones to 0x0A0 masks pins and writing ones to 0x0C0 unmasks them. The mask word reads at 0x0A0, and 0x0C0 reads 0.
- R10: `irq` is high exactly when some status bit is set whose mask bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 9 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NPINS | Synchronised pad levels |
| pad_out | output | NPINS | Output levels |
| pad_oe | output | NPINS | Output enables, 1 = drive |
| irq | output | 1 | Bank interrupt |

## Verification
Four neighbouring pins are configured for rising, falling, both and no trigger, and then all four pads are raised together and lowered together. The raise must set exactly the rising and both pins. The lower must set exactly the falling and both pins. This separates each trigger code from its neighbours and from code 0. A clear is issued in the same cycle as a new edge, which separates a set-dominant status bit from a clear-dominant one. Masking one latched pin while others are clear shows whether `irq` honours the mask bit by bit. The set/clear and mask/unmask pairs are each driven with patterns that leave some bits untouched, to show that zeros have no effect.

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [8:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);

  localparam logic [2:0] A_OUT = 3'd0, A_IN = 3'd1, A_SET = 3'd2, A_CLR = 3'd3,
                         A_STAT = 3'd4, A_MSK = 3'd5, A_UMSK = 3'd6;

  logic [NPINS-1:0] dir_q, out_q, stat_q, mask_q, prev_q, hit;
  logic [1:0]       trig_q [NPINS];

  wire              ctl_sel = bus_addr[8];
  wire              bank_ok = !bus_addr[8] && (bus_addr[4:2] == 3'd0);
  wire [NPINS-1:0]  wd      = bus_wdata[NPINS-1:0];
  wire [NPINS-1:0]  rise    = pad_in & ~prev_q;
  wire [NPINS-1:0]  fall    = ~pad_in & prev_q;

  wire wr_set  = bus_we && bank_ok && bus_addr[7:5] == A_SET;
  wire wr_clr  = bus_we && bank_ok && bus_addr[7:5] == A_CLR;
  wire wr_stat = bus_we && bank_ok && bus_addr[7:5] == A_STAT;
  wire wr_msk  = bus_we && bank_ok && bus_addr[7:5] == A_MSK;
  wire wr_umsk = bus_we && bank_ok && bus_addr[7:5] == A_UMSK;

  always_comb
    for (int i = 0; i < NPINS; i++)
      hit[i] = (trig_q[i][0] & rise[i]) | (trig_q[i][1] & fall[i]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      out_q  <= '0;
      stat_q <= '0;
      mask_q <= '1;
      prev_q <= '0;
      for (int i = 0; i < NPINS; i++) trig_q[i] <= 2'd0;
    end else begin
      prev_q <= pad_in;
      for (int i = 0; i < NPINS; i++)
        if (bus_we && ctl_sel && bus_addr[7:2] == 6'(i)) begin
          dir_q[i]  <= bus_wdata[0];
          trig_q[i] <= bus_wdata[4:3];
        end
      if (wr_set)  out_q  <= out_q | wd;
      if (wr_clr)  out_q  <= out_q & ~wd;
      if (wr_msk)  mask_q <= mask_q | wd;
      if (wr_umsk) mask_q <= mask_q & ~wd;
      stat_q <= (stat_q & ~(wr_stat ? wd : '0)) | hit;
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;
  assign irq     = |(stat_q & ~mask_q);

  always_comb begin
    bus_rdata = '0;
    if (ctl_sel) begin
      for (int i = 0; i < NPINS; i++)
        if (bus_addr[7:2] == 6'(i)) begin
          bus_rdata[0]   = dir_q[i];
          bus_rdata[4:3] = trig_q[i];
        end
    end else if (bank_ok) begin
      case (bus_addr[7:5])
        A_OUT:   bus_rdata[NPINS-1:0] = out_q;
        A_IN:    bus_rdata[NPINS-1:0] = pad_in;
        A_STAT:  bus_rdata[NPINS-1:0] = stat_q;
        A_MSK:   bus_rdata[NPINS-1:0] = mask_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[g] && !(wr_stat && bus_wdata[g])) |=> stat_q[g]);
    assert_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[g] && trig_q[g] == 2'd0) |=> !stat_q[g]);
    assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_msk && bus_wdata[g]) |=> mask_q[g]);
    assert_unmask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_umsk && bus_wdata[g]) |=> !mask_q[g]);
    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set && bus_wdata[g]) |=> pad_out[g]);
    assert_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_q[g] == 2'd1 && pad_in[g] && !prev_q[g]) |=> stat_q[g]);
  end

endmodule

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;
  localparam int N = 32;
  logic clk = 0, rst_n = 0, we = 0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] pin = '0, pout, poe;
  logic irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gpio_edge_bank #(.NPINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .pad_in(pin), .pad_out(pout), .pad_oe(poe), .irq(irq));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 oe", poe, 0); check("R1 out", pout, 0); check("R1 irq", irq, 0);
    rd(9'h0A0, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(9'h080, v); check("R1 stat", v, 0);
    rd(9'h11C, v); check("R1 ctl7 input", v, 1);
  endtask

  task automatic t_dir;
    logic [31:0] v;
    wr(9'h10C, 0); check("R2 oe pin3", poe, 32'h8);
    rd(9'h10C, v); check("R2 ctl3 read", v, 0);
    wr(9'h10C, 32'hFFFF_FFFE); rd(9'h10C, v); check("R2 ctl3 bits", v, 32'h18);
    check("R2 oe still out", poe, 32'h8);
  endtask

  task automatic t_out;
    logic [31:0] v;
    wr(9'h040, 32'hF0); check("R3 set", pout, 32'hF0);
    rd(9'h000, v); check("R3 out read", v, 32'hF0);
    rd(9'h040, v); check("R3 set reads 0", v, 0);
    wr(9'h060, 32'h30); check("R3 clear", pout, 32'hC0);
    rd(9'h060, v); check("R3 clr reads 0", v, 0);
  endtask

  task automatic t_in;
    logic [31:0] v;
    @(negedge clk); pin = 32'hA5A5_0F0F;
    rd(9'h020, v); check("R4 input", v, 32'hA5A5_0F0F);
    @(negedge clk); pin = 0;
    @(negedge clk);
  endtask

  task automatic t_edges;
    logic [31:0] v;
    wr(9'h100, 32'h09); wr(9'h104, 32'h11); wr(9'h108, 32'h19); wr(9'h10C, 32'h01);
    wr(9'h0C0, 32'hF); wr(9'h080, 32'hFFFF_FFFF);
    @(negedge clk); pin[3:0] = 4'hF;
    @(negedge clk); rd(9'h080, v); check("R5 R6 rise", v, 32'h5);
    check("R10 irq on", irq, 1);
    wr(9'h080, 32'hF); check("R7 cleared irq", irq, 0);
    @(negedge clk); pin[3:0] = 4'h0;
    @(negedge clk); rd(9'h080, v); check("R5 R6 fall", v, 32'h6);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(9'h080, 32'h2); rd(9'h080, v); check("R7 w1c one bit", v, 32'h4);
    wr(9'h080, 32'h0); rd(9'h080, v); check("R7 zero no effect", v, 32'h4);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(9'h0A0, 32'h4); check("R10 masked irq", irq, 0);
    rd(9'h0A0, v); check("R9 mask read", v & 32'hF, 32'h4);
    rd(9'h0C0, v); check("R9 umask reads 0", v, 0);
    wr(9'h0C0, 32'h4); check("R10 unmasked irq", irq, 1);
    wr(9'h080, 32'hF);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk); pin[0] = 1; we = 1; addr = 9'h080; wdata = 32'h1;
    @(negedge clk); we = 0;
    rd(9'h080, v); check("R8 event beats clear", v & 32'h1, 32'h1);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_dir; t_out; t_in; t_edges; t_w1c; t_mask; t_collide;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule